// File: doc/BRIEF.md
# Power-Down Clock Stop Sequencer

This block orders the shutdown and restart of a clock generator that drives several output clocks. An active-low power-down request arrives at any time, with no relation to any clock. It is synchronized into a reference clock domain, and from there into every output clock domain. Each output parks low on its own falling edge. Only when every output has reported that it is parked does the sequencer drop the VCO enable. The crystal-oscillator enable follows one reference cycle later.

When the request is released, the crystal enable rises first and the VCO enable follows one cycle later. A programmable lock interval then runs before the output gates open. Outputs can be single-ended or complementary pairs. A pair has a true leg and an opposite-phase leg, and when stopped both legs sit low. The oscillator and PLLs exist here only as the two enable strobes. The reference clock is assumed to keep running.

Top module: `pdn_clk_sequencer`

## Requirements
- R1: `xtal_en` rises on the third rising `ref_clk` edge after `pd_req_n` is presented high: two synchronizer stages and one state edge. The same applies after reset is released.
- R2: `vco_en` rises exactly one `ref_clk` cycle after `xtal_en`, and it is never high while `xtal_en` is low.
- R3: After `vco_en` rises, every output stays low for LOCK_CYC `ref_clk` cycles. After that, every output toggles for as long as `pd_req_n` stays high, including both legs of each pair.
- R4: After `pd_req_n` goes low, each true leg stops low at a falling edge of its source clock. The complement leg (source inverted) stops at its own falling edge, which is a rising edge of the source. Both legs of a pair end low and stay low.
- R5: `vco_en` falls only when every output is parked low. No output makes an edge while `vco_en` is low.
- R6: `xtal_en` falls exactly one `ref_clk` cycle after `vco_en` falls. A completed power-down leaves both enables low.
- R7: Gating is glitch-free. Every high pulse on every output lasts a full half period of its source clock, at start as well as at stop.
- R8: A request that arrives during the lock interval drops `vco_en` on the third rising `ref_clk` edge and `xtal_en` on the fourth. No output edge is released.
- R9: A stop that has begun runs to completion, with both enables dropped, even if `pd_req_n` returns high midway. A normal wake sequence then follows.
- R10: Reset (`rst_n` low) forces every output and both enables low at once. The block leaves reset in the powered-down state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock that runs the sequencing state machine |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_req_n | input | 1 | Asynchronous active-low power-down request |
| src_clk | input | N_DOM | Free-running source clock of each output domain |
| clk_out | output | N_DOM | Gated true leg of each output domain |
| clk_out_b | output | N_PAIR | Gated complement leg of domains 0 to N_PAIR-1 |
| xtal_en | output | 1 | Crystal-oscillator enable |
| vco_en | output | 1 | PLL/VCO enable |

## Verification
The assertions rely on three things about the inputs. Each source clock toggles with a clean 50% duty cycle whenever `vco_en` is high, and it may stop low when `vco_en` is low. `ref_clk` never stops. Any level of `pd_req_n` lasts for several reference cycles. The stimulus meets these conditions. It changes the request only on falling reference edges and holds each level for at least three cycles. The modelled source clocks start and stop only at their own half-period ticks, and they run only while the VCO enable is high, so every gated pulse can be measured against a known half period.

// File: rtl/pdn_pkg.sv
package pdn_pkg;

   // Sequencer states, ordered from fully off through running and back.
   typedef enum logic [2:0] {
      ST_OFF    = 3'd0,
      ST_XTAL   = 3'd1,
      ST_LOCK   = 3'd2,
      ST_START  = 3'd3,
      ST_RUN    = 3'd4,
      ST_STOP   = 3'd5,
      ST_VCO_DN = 3'd6
   } pdn_state_e;

   // Enable strobes produced for a given state.
   typedef struct packed {
      logic xtal;
      logic vco;
      logic run;
   } pdn_ctl_t;

   function automatic pdn_ctl_t ctl_of(pdn_state_e st);
      pdn_ctl_t c;
      c.xtal = (st != ST_OFF);
      c.vco  = (st == ST_LOCK) || (st == ST_START) || (st == ST_RUN) || (st == ST_STOP);
      c.run  = (st == ST_START) || (st == ST_RUN);
      return c;
   endfunction

   function automatic int cnt_width(int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/pdn_sync.sv
module pdn_sync #(
   parameter int   WIDTH   = 1,
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("pdn_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("pdn_sync: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < STAGES; k++) begin
            stg[k] <= {WIDTH{RST_VAL}};
         end
      end else begin
         stg[0] <= d;
         for (int k = 1; k < STAGES; k++) begin
            stg[k] <= stg[k-1];
         end
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/pdn_gate.sv
module pdn_gate #(
   parameter int LEGS   = 1,
   parameter int STAGES = 2
) (
   input  logic            src_clk,
   input  logic            rst_n,
   input  logic            run_req,
   output logic [LEGS-1:0] legs,
   output logic            run_ack,
   output logic            idle_ack
);

   if (LEGS != 1 && LEGS != 2) begin : g_bad_legs
      $error("pdn_gate: LEGS must be 1 or 2");
   end

   logic run_s;
   logic en_t;

   pdn_sync #(.WIDTH(1), .STAGES(STAGES), .RST_VAL(1'b0)) u_sync (
      .clk   (src_clk),
      .rst_n (rst_n),
      .d     (run_req),
      .q     (run_s)
   );

   // True leg: the enable changes only while the source is low.
   always_ff @(negedge src_clk or negedge rst_n) begin
      if (!rst_n) en_t <= 1'b0;
      else        en_t <= run_s;
   end

   assign legs[0] = src_clk & en_t;

   if (LEGS == 2) begin : g_pair
      logic en_c;
      // Complement leg: the enable changes while the inverted source is low,
      // trailing the true leg by half a source period.
      always_ff @(posedge src_clk or negedge rst_n) begin
         if (!rst_n) en_c <= 1'b0;
         else        en_c <= en_t;
      end
      assign legs[1]  = ~src_clk & en_c;
      assign run_ack  = en_t & en_c;
      assign idle_ack = ~(en_t | en_c);
   end else begin : g_single
      assign run_ack  = en_t;
      assign idle_ack = ~en_t;
   end

endmodule

// File: rtl/pdn_ctrl.sv
module pdn_ctrl
   import pdn_pkg::*;
#(
   parameter int LOCK_CYC = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_on,
   input  logic all_run,
   input  logic all_idle,
   output logic xtal_en,
   output logic vco_en,
   output logic run_req
);

   localparam int CW = cnt_width(LOCK_CYC);
   localparam logic [CW-1:0] LOCK_LAST = CW'(LOCK_CYC - 1);

   if (LOCK_CYC < 1) begin : g_bad_lock
      $error("pdn_ctrl: LOCK_CYC must be at least 1");
   end

   pdn_state_e st, st_nxt;
   logic [CW-1:0] lock_cnt;
   pdn_ctl_t ctl_nxt;

   always_comb begin
      st_nxt = st;
      unique case (st)
         ST_OFF:    if (req_on) st_nxt = ST_XTAL;
         ST_XTAL:   st_nxt = req_on ? ST_LOCK : ST_OFF;
         ST_LOCK: begin
            if (!req_on)                     st_nxt = ST_VCO_DN;
            else if (lock_cnt == LOCK_LAST)  st_nxt = ST_START;
         end
         ST_START:  if (all_run)  st_nxt = ST_RUN;
         ST_RUN:    if (!req_on)  st_nxt = ST_STOP;
         ST_STOP:   if (all_idle) st_nxt = ST_VCO_DN;
         ST_VCO_DN: st_nxt = ST_OFF;
         default:   st_nxt = ST_OFF;
      endcase
   end

   assign ctl_nxt = ctl_of(st_nxt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_OFF;
         lock_cnt <= '0;
         xtal_en  <= 1'b0;
         vco_en   <= 1'b0;
         run_req  <= 1'b0;
      end else begin
         st       <= st_nxt;
         lock_cnt <= (st == ST_LOCK) ? lock_cnt + 1'b1 : '0;
         xtal_en  <= ctl_nxt.xtal;
         vco_en   <= ctl_nxt.vco;
         run_req  <= ctl_nxt.run;
      end
   end

endmodule

// File: rtl/pdn_clk_sequencer.sv
module pdn_clk_sequencer #(
   parameter int N_DOM       = 4,
   parameter int N_PAIR      = 1,
   parameter int LOCK_CYC    = 64,
   parameter int SYNC_STAGES = 2
) (
   input  logic              ref_clk,
   input  logic              rst_n,
   input  logic              pd_req_n,
   input  logic [N_DOM-1:0]  src_clk,
   output logic [N_DOM-1:0]  clk_out,
   output logic [N_PAIR-1:0] clk_out_b,
   output logic              xtal_en,
   output logic              vco_en
);

   localparam int ACK_W = 2 * N_DOM;

   if (N_DOM < 1) begin : g_bad_dom
      $error("pdn_clk_sequencer: N_DOM must be at least 1");
   end
   if (N_PAIR < 1 || N_PAIR > N_DOM) begin : g_bad_pair
      $error("pdn_clk_sequencer: N_PAIR must lie in 1..N_DOM");
   end

   logic             req_on;
   logic             run_req;
   logic [N_DOM-1:0] run_ack, idle_ack;
   logic [ACK_W-1:0] ack_s;
   logic [N_DOM-1:0] run_s, idle_s;

   // Request into the reference domain; reset value means "powered down".
   pdn_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_req_sync (
      .clk   (ref_clk),
      .rst_n (rst_n),
      .d     (pd_req_n),
      .q     (req_on)
   );

   for (genvar i = 0; i < N_DOM; i++) begin : g_dom
      if (i < N_PAIR) begin : g_p
         pdn_gate #(.LEGS(2), .STAGES(SYNC_STAGES)) u_gate (
            .src_clk  (src_clk[i]),
            .rst_n    (rst_n),
            .run_req  (run_req),
            .legs     ({clk_out_b[i], clk_out[i]}),
            .run_ack  (run_ack[i]),
            .idle_ack (idle_ack[i])
         );
      end else begin : g_s
         pdn_gate #(.LEGS(1), .STAGES(SYNC_STAGES)) u_gate (
            .src_clk  (src_clk[i]),
            .rst_n    (rst_n),
            .run_req  (run_req),
            .legs     (clk_out[i]),
            .run_ack  (run_ack[i]),
            .idle_ack (idle_ack[i])
         );
      end
   end

   // Domain acknowledgements back into the reference domain.
   pdn_sync #(.WIDTH(ACK_W), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_ack_sync (
      .clk   (ref_clk),
      .rst_n (rst_n),
      .d     ({idle_ack, run_ack}),
      .q     (ack_s)
   );

   assign run_s  = ack_s[N_DOM-1:0];
   assign idle_s = ack_s[ACK_W-1:N_DOM];

   pdn_ctrl #(.LOCK_CYC(LOCK_CYC)) u_ctrl (
      .clk      (ref_clk),
      .rst_n    (rst_n),
      .req_on   (req_on),
      .all_run  (&run_s),
      .all_idle (&idle_s),
      .xtal_en  (xtal_en),
      .vco_en   (vco_en),
      .run_req  (run_req)
   );

endmodule

// File: rtl/pdn_clk_sequencer_chk.sv
module pdn_clk_sequencer_chk #(
   parameter int N_DOM    = 4,
   parameter int N_PAIR   = 1,
   parameter int LOCK_CYC = 64
) (
   input logic              ref_clk,
   input logic              rst_n,
   input logic              xtal_en,
   input logic              vco_en,
   input logic [N_DOM-1:0]  clk_out,
   input logic [N_PAIR-1:0] clk_out_b
);

   localparam int LW = $clog2(LOCK_CYC + 1);

   logic [LW-1:0] lk;
   logic          outs_low;

   assign outs_low = ({clk_out_b, clk_out} == '0);

   // Reference cycles seen with the VCO enabled, saturating at LOCK_CYC.
   always_ff @(posedge ref_clk or negedge rst_n) begin
      if (!rst_n)                     lk <= '0;
      else if (!vco_en)               lk <= '0;
      else if (lk != LW'(LOCK_CYC))   lk <= lk + 1'b1;
   end

   a_r2_vco_needs_xtal: assert property (@(posedge ref_clk) disable iff (!rst_n)
      vco_en |-> xtal_en);

   a_r3_lock_hold: assert property (@(posedge ref_clk) disable iff (!rst_n)
      (vco_en && (lk < LW'(LOCK_CYC))) |-> outs_low);

   a_r5_parked_before_vco_off: assert property (@(posedge ref_clk) disable iff (!rst_n)
      $fell(vco_en) |-> outs_low);

   a_r5_quiet_while_vco_off: assert property (@(posedge ref_clk) disable iff (!rst_n)
      !vco_en |-> outs_low);

   a_r6_xtal_follows_vco: assert property (@(posedge ref_clk) disable iff (!rst_n)
      $fell(vco_en) |=> $fell(xtal_en));

endmodule

bind pdn_clk_sequencer pdn_clk_sequencer_chk #(
   .N_DOM    (N_DOM),
   .N_PAIR   (N_PAIR),
   .LOCK_CYC (LOCK_CYC)
) u_chk (
   .ref_clk   (ref_clk),
   .rst_n     (rst_n),
   .xtal_en   (xtal_en),
   .vco_en    (vco_en),
   .clk_out   (clk_out),
   .clk_out_b (clk_out_b)
);

// File: tb/sim_pdn_clk_sequencer.sv
`timescale 1ns/1ps
module sim_pdn_clk_sequencer;

   localparam int N_DOM = 4;
   localparam int N_PAIR = 1;
   localparam int LOCK = 8;
   localparam int NMON = N_DOM + N_PAIR;
   localparam int HALF_NS [N_DOM] = '{7, 9, 11, 13};
   localparam int MON_HALF [NMON] = '{7, 9, 11, 13, 7};

   typedef struct packed {
      logic       pd;
      int         cyc;
      logic       xt;
      logic       vc;
      logic [1:0] act;   // 0: silent and low, 1: all toggle, 2: don't care
   } vec_t;

   localparam int NV = 13;
   localparam vec_t VECS [NV] = '{
      '{1'b1, 2,    1'b0, 1'b0, 2'd0},
      '{1'b1, 1,    1'b1, 1'b0, 2'd0},
      '{1'b1, 1,    1'b1, 1'b1, 2'd0},
      '{1'b1, LOCK, 1'b1, 1'b1, 2'd0},
      '{1'b1, 12,   1'b1, 1'b1, 2'd1},
      '{1'b1, 20,   1'b1, 1'b1, 2'd1},
      '{1'b0, 40,   1'b0, 1'b0, 2'd2},
      '{1'b0, 20,   1'b0, 1'b0, 2'd0},
      '{1'b1, 2,    1'b0, 1'b0, 2'd0},
      '{1'b1, 1,    1'b1, 1'b0, 2'd0},
      '{1'b1, 1,    1'b1, 1'b1, 2'd0},
      '{1'b1, LOCK, 1'b1, 1'b1, 2'd0},
      '{1'b1, 20,   1'b1, 1'b1, 2'd1}
   };
   localparam string TAGS [NV] = '{"R1", "R1", "R2", "R3", "R3", "R3", "R6",
                                   "R4", "R1", "R1", "R2", "R3", "R3"};

   logic ref_clk = 1'b0;
   logic rst_n = 1'b0;
   logic pd_req_n = 1'b1;
   logic [N_DOM-1:0] src_clk;
   logic [N_DOM-1:0] clk_out;
   logic [N_PAIR-1:0] clk_out_b;
   logic xtal_en, vco_en;
   logic [NMON-1:0] mon;

   int checks = 0;
   int fails = 0;
   int vco_falls = 0;
   int base [NMON];

   always #10 ref_clk = ~ref_clk;

   pdn_clk_sequencer #(.N_DOM(N_DOM), .N_PAIR(N_PAIR), .LOCK_CYC(LOCK), .SYNC_STAGES(2)) u0 (
      .ref_clk(ref_clk), .rst_n(rst_n), .pd_req_n(pd_req_n), .src_clk(src_clk),
      .clk_out(clk_out), .clk_out_b(clk_out_b), .xtal_en(xtal_en), .vco_en(vco_en)
   );

   assign mon = {clk_out_b, clk_out};

   // Source clocks run only while the VCO is enabled.
   for (genvar i = 0; i < N_DOM; i++) begin : g_src
      logic s = 1'b0;
      initial begin
         forever begin
            #(HALF_NS[i]);
            s = vco_en ? ~s : 1'b0;
         end
      end
      assign src_clk[i] = s;
   end

   // Per-output edge counting and high-pulse width measurement.
   for (genvar i = 0; i < NMON; i++) begin : g_mon
      int cnt = 0;
      int cnt_dn = 0;
      int glitch = 0;
      bit seen = 1'b0;
      realtime t_up = 0.0;
      always @(posedge mon[i]) begin
         t_up = $realtime;
         seen = 1'b1;
         cnt++;
         if (!vco_en) cnt_dn++;
      end
      always @(negedge mon[i]) begin
         if (rst_n && seen && ($realtime - t_up < MON_HALF[i] - 0.5)) glitch++;
      end
   end

   always @(negedge vco_en) vco_falls++;

   function automatic int edges_of(int k);
      case (k)
         0: return g_mon[0].cnt;
         1: return g_mon[1].cnt;
         2: return g_mon[2].cnt;
         3: return g_mon[3].cnt;
         4: return g_mon[4].cnt;
         default: return 0;
      endcase
   endfunction

   task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic snap();
      for (int k = 0; k < NMON; k++) base[k] = edges_of(k);
   endtask

   function automatic int min_delta();
      int m = 1 << 30;
      for (int k = 0; k < NMON; k++) if (edges_of(k) - base[k] < m) m = edges_of(k) - base[k];
      return m;
   endfunction

   function automatic int sum_delta();
      int s = 0;
      for (int k = 0; k < NMON; k++) s += edges_of(k) - base[k];
      return s;
   endfunction

   task automatic cyc(input int n);
      repeat (n) @(negedge ref_clk);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   initial begin
      #1_000_000;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      checks++;
      fails++;
      summary();
      $finish;
   end

   initial begin
      int vf0;
      // R10: reset state
      cyc(3);
      chk(mon == '0, "R10", "outputs in reset", int'(mon), 0);
      chk(xtal_en == 1'b0 && vco_en == 1'b0, "R10", "enables in reset", int'({xtal_en, vco_en}), 0);
      rst_n = 1'b1;

      // Vector table walk
      for (int v = 0; v < NV; v++) begin
         pd_req_n = VECS[v].pd;
         snap();
         cyc(VECS[v].cyc);
         chk(xtal_en == VECS[v].xt, TAGS[v], $sformatf("xtal_en vec %0d", v), int'(xtal_en), int'(VECS[v].xt));
         chk(vco_en == VECS[v].vc, TAGS[v], $sformatf("vco_en vec %0d", v), int'(vco_en), int'(VECS[v].vc));
         if (VECS[v].act == 2'd0) begin
            chk(sum_delta() == 0 && mon == '0, TAGS[v], $sformatf("outputs silent low vec %0d", v),
                sum_delta() + int'(mon), 0);
         end else if (VECS[v].act == 2'd1) begin
            chk(min_delta() > 0, TAGS[v], $sformatf("every leg toggling vec %0d", v), min_delta(), 1);
         end
      end

      // R8: request during lock wait
      pd_req_n = 1'b0;
      cyc(40);
      pd_req_n = 1'b1;
      cyc(5);
      chk(vco_en == 1'b1, "R8", "in lock interval", int'(vco_en), 1);
      snap();
      pd_req_n = 1'b0;
      cyc(3);
      chk(vco_en == 1'b0 && xtal_en == 1'b1, "R8", "vco off, xtal on", int'({xtal_en, vco_en}), 2);
      cyc(1);
      chk(vco_en == 1'b0 && xtal_en == 1'b0, "R8", "both off", int'({xtal_en, vco_en}), 0);
      chk(sum_delta() == 0, "R8", "no output edge", sum_delta(), 0);

      // R9: release during an ongoing stop
      pd_req_n = 1'b1;
      cyc(40);
      chk(min_delta() > 0, "R9", "running before stop", min_delta(), 1);
      vf0 = vco_falls;
      pd_req_n = 1'b0;
      cyc(4);
      pd_req_n = 1'b1;
      cyc(60);
      chk(vco_falls - vf0 == 1, "R9", "stop completed", vco_falls - vf0, 1);
      snap();
      cyc(20);
      chk(xtal_en && vco_en && (min_delta() > 0), "R9", "wake after stop", min_delta(), 1);

      // R10: reset while running
      @(negedge ref_clk);
      rst_n = 1'b0;
      #1;
      chk(mon == '0, "R10", "outputs cleared by reset", int'(mon), 0);
      chk(xtal_en == 1'b0 && vco_en == 1'b0, "R10", "enables cleared by reset", int'({xtal_en, vco_en}), 0);
      cyc(3);
      rst_n = 1'b1;
      cyc(2);
      chk(xtal_en == 1'b0, "R10", "xtal off two cycles after reset", int'(xtal_en), 0);
      cyc(1);
      chk(xtal_en == 1'b1, "R1", "xtal on third cycle after reset", int'(xtal_en), 1);
      cyc(1);
      chk(vco_en == 1'b1, "R2", "vco follows xtal", int'(vco_en), 1);
      cyc(LOCK + 20);

      // R5 and R7: totals over the whole run
      begin
         int gl = g_mon[0].glitch + g_mon[1].glitch + g_mon[2].glitch + g_mon[3].glitch + g_mon[4].glitch;
         int dn = g_mon[0].cnt_dn + g_mon[1].cnt_dn + g_mon[2].cnt_dn + g_mon[3].cnt_dn + g_mon[4].cnt_dn;
         chk(gl == 0, "R7", "short high pulses", gl, 0);
         chk(dn == 0, "R5", "edges while vco off", dn, 0);
      end

      summary();
      $finish;
   end

endmodule